// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a bus-mapped watchdog for a processor subsystem. Software arms it with a single write to its control register. That write sets a 16-bit reload value, an optional coarse prescale, a freeze control, and whether an expiry raises an interrupt or requests a reset. After the first write the control register is frozen, so the watchdog can never be turned off once it is running. It also can never be turned on later if the first write left it off.

The counter is held alive by a two-step key written to the service register. The arming key 16'h556C must be followed by the firing key 16'hAA39. Only that ordered pair reloads the counter. A live count register exposes the remaining time. A cause flag remembers that a reset was requested by the watchdog. The cause flag sits in the power-on reset domain only, so it survives the system reset that the watchdog itself triggers.

Top module: `wdt_keyed`

## Requirements
- R1: Register map by byte address: control at 0x0, count at 0x4 (counter in bits 15:0), service at 0x8 (key in bits 15:0), cause at 0xC (flag in bit 0). Undefined bits and the service register read as zero. After reset the control register reads 32'hFFFF0003 and the count reads 16'hFFFF.
- R2: The first control write after reset captures its fields. Bits 31:16 are the reload count, bit 3 is freeze, bit 2 is enable, bit 1 selects the mode (1 = reset request, 0 = interrupt) and bit 0 turns on the prescale. The same write loads the counter with the new reload count.
- R3: Every later control write is ignored, including its enable, mode and count fields. The readback keeps showing the captured value.
- R4: While enabled and not frozen, the counter falls by one per tick. A tick comes every clock when bit 0 is 0, and every PRE_DIV clocks when bit 0 is 1. A tick that finds the counter at zero is an expiry, and the counter reloads and keeps running. With reload N, the first expiry is the (N+1)-th tick after the load.
- R5: While disabled or frozen, the counter holds its value and no expiry occurs.
- R6: A write of 16'hAA39 to the service register reloads the counter and restarts the prescale only if the previous service write was 16'h556C. Repeated 16'h556C writes stay armed. Any other value, or 16'hAA39 when not armed, disarms without a reload. Writes to other registers do not affect arming.
- R7: In interrupt mode, an expiry sets wdt_irq, which stays high until a valid key pair completes. A key completion in the same cycle as a would-be expiry wins, and no expiry occurs.
- R8: In reset mode, each expiry drives wdt_reset_req high for exactly one clock cycle and sets the cause flag.
- R9: The cause flag is kept through rst_n. It is cleared by por_n or by writing 1 to bit 0 at 0xC. Writing 0 has no effect, and a set in the same cycle wins over a clear.
- R10: rst_n or por_n returns all other state to its reset value. This unlocks the control register for one more first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, asynchronous |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| wdt_irq | output | 1 | Level interrupt on expiry in interrupt mode |
| wdt_reset_req | output | 1 | One-cycle reset request on expiry in reset mode |

## Verification
A reference model in the bench follows every cycle. It is driven by random streams of service writes mixing valid pairs, lone arming keys, lone firing keys, repeated arming keys and arbitrary values. These streams separate a checker that reloads only on the ordered pair from one that accepts either key alone or forgets its armed state. The random stream also writes to the count, control and cause registers. This shows that locked or read-only registers ignore writes while the counter keeps running. Directed cases cover:
- a key pair landing on the very tick that would expire;
- freeze and disabled-at-first-write configurations;
- the prescaled tick spacing;
- cause-flag survival across rst_n versus clearing by por_n.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int          PRE_DIV  = 65536,
  parameter int          ADDR_W   = 4,
  parameter logic [15:0] KEY_ARM  = 16'h556C,
  parameter logic [15:0] KEY_FIRE = 16'hAA39,
  parameter logic [31:0] RST_CTRL = 32'hFFFF_0003
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_irq,
  output logic              wdt_reset_req
);
  localparam int          PRE_W     = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
  localparam logic [31:0] CTRL_MASK = 32'hFFFF_000F;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SVC   = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(12);

  logic [31:0]      ctrl_q;
  logic             locked_q;
  logic [15:0]      cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             armed_q;
  logic             cause_q;

  wire rst_all_n = por_n & rst_n;
  wire wr        = bus_sel & bus_we;
  wire wr_ctrl   = wr && (bus_addr == A_CTRL);
  wire wr_svc    = wr && (bus_addr == A_SVC);
  wire wr_cause  = wr && (bus_addr == A_CAUSE);

  wire [15:0] reload  = ctrl_q[31:16];
  wire        frz     = ctrl_q[3];
  wire        en      = ctrl_q[2];
  wire        rst_mode = ctrl_q[1];
  wire        pre_on  = ctrl_q[0];

  wire take     = wr_ctrl & ~locked_q;
  wire svc_fire = wr_svc && (bus_wdata[15:0] == KEY_FIRE) && armed_q;
  wire run      = en & ~frz;
  wire pre_wrap = (pre_q == PRE_LAST);
  wire tick     = run & (~pre_on | pre_wrap);
  wire expire   = tick && (cnt_q == 16'd0) && !svc_fire && !take;

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      ctrl_q   <= RST_CTRL;
      locked_q <= 1'b0;
    end else if (take) begin
      ctrl_q   <= bus_wdata & CTRL_MASK;
      locked_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      cnt_q <= RST_CTRL[31:16];
      pre_q <= '0;
    end else if (take) begin
      cnt_q <= bus_wdata[31:16];
      pre_q <= '0;
    end else if (svc_fire) begin
      cnt_q <= reload;
      pre_q <= '0;
    end else begin
      if (tick) cnt_q <= (cnt_q == 16'd0) ? reload : cnt_q - 16'd1;
      if (run && pre_on) pre_q <= pre_wrap ? '0 : pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      armed_q       <= 1'b0;
      wdt_irq       <= 1'b0;
      wdt_reset_req <= 1'b0;
    end else begin
      if (wr_svc) armed_q <= (bus_wdata[15:0] == KEY_ARM);
      if (svc_fire) wdt_irq <= 1'b0;
      else if (expire && !rst_mode) wdt_irq <= 1'b1;
      wdt_reset_req <= expire & rst_mode;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause_q <= 1'b0;
    else if (!rst_n) cause_q <= cause_q;
    else if (expire && rst_mode) cause_q <= 1'b1;
    else if (wr_cause && bus_wdata[0]) cause_q <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_CNT:   bus_rdata = {16'd0, cnt_q};
      A_CAUSE: bus_rdata = {31'd0, cause_q};
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk (
  input logic        clk,
  input logic        por_n,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [31:0] ctrl_q,
  input logic        locked_q,
  input logic [15:0] cnt_q,
  input logic        irq,
  input logic        req,
  input logic        cause_q
);
  wire rst_all_n = por_n & rst_n;

  assert_ctrl_locked_R3: assert property (@(posedge clk) disable iff (!rst_all_n)
    locked_q |=> $stable(ctrl_q));

  assert_irq_from_zero_R7: assert property (@(posedge clk) disable iff (!rst_all_n)
    $rose(irq) |-> ($past(cnt_q) == 16'd0));

  assert_req_sets_cause_R8: assert property (@(posedge clk) disable iff (!rst_all_n)
    req |-> cause_q);

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_all_n)
    !ctrl_q[2] |-> (!irq && !req));

  assert_freeze_holds_R5: assert property (@(posedge clk) disable iff (!rst_all_n)
    (ctrl_q[3] && !(bus_sel && bus_we)) |=> $stable(cnt_q));
endmodule

bind wdt_keyed wdt_keyed_chk u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .ctrl_q(ctrl_q), .locked_q(locked_q), .cnt_q(cnt_q),
  .irq(wdt_irq), .req(wdt_reset_req), .cause_q(cause_q)
);

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;
  localparam int P = 16;
  localparam logic [15:0] K_ARM  = 16'h556C;
  localparam logic [15:0] K_FIRE = 16'hAA39;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        por_n = 1'b0, rst_n = 1'b0, bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h4;
  logic [31:0] bus_wdata = 32'd0;
  wire  [31:0] bus_rdata;
  wire         irq, req;

  wdt_keyed #(.PRE_DIV(P)) u_wdt_keyed (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_irq(irq), .wdt_reset_req(req)
  );

  int checks = 0, fails = 0;
  bit mon_on = 1'b0, done = 1'b0;

  logic [31:0] m_ctrl;
  logic        m_lock, m_armed, m_irq, m_req, m_cause;
  logic [15:0] m_cnt;
  int          m_pre;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_clear();
    m_ctrl = 32'hFFFF_0003; m_lock = 0; m_cnt = 16'hFFFF; m_pre = 0;
    m_armed = 0; m_irq = 0; m_req = 0;
  endtask

  task automatic m_step();
    logic w, take, fire, run, tick, ex;
    w    = bus_sel && bus_we;
    take = w && bus_addr == 4'h0 && !m_lock;
    fire = w && bus_addr == 4'h8 && bus_wdata[15:0] == K_FIRE && m_armed;
    run  = m_ctrl[2] && !m_ctrl[3];
    tick = run && (!m_ctrl[0] || m_pre == P - 1);
    ex   = tick && m_cnt == 16'd0 && !fire && !take;
    if (w && bus_addr == 4'h8) m_armed = (bus_wdata[15:0] == K_ARM);
    if (fire) m_irq = 0; else if (ex && !m_ctrl[1]) m_irq = 1;
    m_req = ex && m_ctrl[1];
    if (ex && m_ctrl[1]) m_cause = 1;
    else if (w && bus_addr == 4'hC && bus_wdata[0]) m_cause = 0;
    if (take) begin m_cnt = bus_wdata[31:16]; m_pre = 0; end
    else if (fire) begin m_cnt = m_ctrl[31:16]; m_pre = 0; end
    else begin
      if (tick) m_cnt = (m_cnt == 16'd0) ? m_ctrl[31:16] : m_cnt - 16'd1;
      if (run && m_ctrl[0]) m_pre = (m_pre == P - 1) ? 0 : m_pre + 1;
    end
    if (take) begin m_ctrl = bus_wdata & 32'hFFFF_000F; m_lock = 1; end
  endtask

  always @(posedge clk or negedge por_n or negedge rst_n) begin
    if (!por_n) begin m_clear(); m_cause = 0; end
    else if (!rst_n) m_clear();
    else m_step();
  end

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a)
      4'h0: return m_ctrl;
      4'h4: return {16'd0, m_cnt};
      4'hC: return {31'd0, m_cause};
      default: return 32'd0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (mon_on && !done) begin
      #2;
      check("R1 R4 readback", bus_rdata, m_read(bus_addr));
      check("R7 irq", {31'd0, irq}, {31'd0, m_irq});
      check("R8 req", {31'd0, req}, {31'd0, m_req});
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_addr = 4'h4;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    bus_addr = a;
    #1 check(tag, bus_rdata, exp);
    bus_addr = 4'h4;
  endtask

  task automatic sys_reset();
    rst_n = 0; @(negedge clk); rst_n = 1;
  endtask

  task automatic rand_phase(int n);
    for (int i = 0; i < n; i++) begin
      case ($urandom_range(0, 8))
        0: idle($urandom_range(1, 25));
        1: begin wr(4'h8, {16'd0, K_ARM}); wr(4'h8, {16'd0, K_FIRE}); end
        2: wr(4'h8, {16'd0, K_ARM});
        3: wr(4'h8, {16'd0, K_FIRE});
        4: wr(4'h8, $urandom);
        5: begin wr(4'h8, {16'd0, K_ARM}); wr(4'h8, {16'd0, K_ARM}); wr(4'h8, {16'd0, K_FIRE}); end
        6: wr(4'h4, $urandom);
        7: wr(4'h0, $urandom);
        default: wr(4'hC, $urandom);
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit seen;
    void'($urandom(32'd4711));
    idle(3);
    por_n = 1; rst_n = 1; mon_on = 1;
    idle(1);
    rd(4'h0, 32'hFFFF_0003, "R1 control reset value");
    rd(4'h4, 32'h0000_FFFF, "R1 count reset value");
    rd(4'hC, 32'd0, "R1 cause reset value");
    idle(10);
    rd(4'h4, 32'h0000_FFFF, "R5 disabled holds");

    wr(4'h0, 32'h0014_0004);
    rd(4'h0, 32'h0014_0004, "R2 capture");
    rd(4'h4, 32'd20, "R2 load");
    wr(4'h0, 32'h0001_0002);
    rd(4'h0, 32'h0014_0004, "R3 second write ignored");
    idle(30);
    check("R7 irq level", {31'd0, irq}, 32'd1);
    wr(4'h8, {16'd0, K_ARM});
    check("R6 half key keeps irq", {31'd0, irq}, 32'd1);
    wr(4'h8, {16'd0, K_FIRE});
    check("R7 irq cleared", {31'd0, irq}, 32'd0);
    rd(4'h4, 32'd20, "R6 reload");
    wr(4'h8, {16'd0, K_ARM}); wr(4'h8, 32'h0000_1234); wr(4'h8, {16'd0, K_FIRE});
    rd(4'h4, 32'd17, "R6 bad key no reload");
    wr(4'h8, {16'd0, K_ARM}); wr(4'h8, {16'd0, K_ARM}); wr(4'h8, {16'd0, K_FIRE});
    rd(4'h4, 32'd20, "R6 repeated arm");
    rand_phase(150);

    sys_reset();
    wr(4'h0, 32'h0003_0004);
    idle(2);
    wr(4'h8, {16'd0, K_ARM}); wr(4'h8, {16'd0, K_FIRE});
    check("R7 service beats expiry", {31'd0, irq}, 32'd0);
    rd(4'h4, 32'd3, "R7 service beats expiry count");

    sys_reset();
    rd(4'h0, 32'hFFFF_0003, "R10 unlocked after reset");
    wr(4'h0, 32'h0005_0006);
    seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      #3 if (req) seen = 1; else @(negedge clk);
    end
    check("R8 reset request seen", {31'd0, seen}, 32'd1);
    @(negedge clk);
    #3 check("R8 one cycle", {31'd0, req}, 32'd0);
    rd(4'hC, 32'd1, "R8 cause set");
    sys_reset();
    rd(4'hC, 32'd1, "R9 cause survives rst_n");
    rd(4'h0, 32'hFFFF_0003, "R10 control restored");
    wr(4'hC, 32'd0);
    rd(4'hC, 32'd1, "R9 write zero ignored");
    wr(4'hC, 32'd1);
    rd(4'hC, 32'd0, "R9 write one clears");
    wr(4'h0, 32'h0002_0006);
    rand_phase(60);
    idle(10);
    rd(4'hC, 32'd1, "R9 cause set again");
    por_n = 0; @(negedge clk); por_n = 1;
    rd(4'hC, 32'd0, "R9 por clears cause");

    sys_reset();
    wr(4'h0, 32'h0003_000C);
    idle(20);
    rd(4'h4, 32'd3, "R5 freeze holds");
    check("R5 freeze no irq", {31'd0, irq}, 32'd0);

    sys_reset();
    wr(4'h0, 32'h0004_0000);
    wr(4'h0, 32'h0004_0004);
    idle(20);
    rd(4'h4, 32'd4, "R5 disabled first write");
    rd(4'h0, 32'h0004_0000, "R3 enable stays off");

    sys_reset();
    wr(4'h0, 32'h0002_0005);
    idle(15);
    rd(4'h4, 32'd2, "R4 prescale hold");
    idle(1);
    rd(4'h4, 32'd1, "R4 prescale step");
    idle(40);
    check("R4 prescale expiry", {31'd0, irq}, 32'd1);
    rand_phase(80);

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule